// File: doc/BRIEF.md
# Min-Sum Check/Bit Processing Element for Successive-Cancellation Polar Decoding

This block is the arithmetic element used in every inner stage of a log-likelihood-ratio successive-cancellation polar decoder. It receives two soft values in sign-magnitude form, a partial-sum bit and a mode select. It returns one soft value in the same form. In check mode it forms the min-sum approximation of the check-node update. In bit mode it combines the two inputs by addition or subtraction, as set by the partial sum, and clips the result to the representable range.

Inside the element both inputs are converted to two's complement. A sum and a difference are built side by side, and each is converted back to sign-magnitude with saturation. The partial sum picks one of them, and the mode select then chooses between the check result and the bit result. The magnitude comparator used in check mode also drives an output flag, which a following two-bit decision node can reuse. A parameter selects whether the result is registered or passed through combinationally. The scheduler, the partial-sum generator and the LLR memories live outside this block.

Top module: `polar_fg_pe`

## Requirements
- R1: In check mode (`mode_g`=0) the output magnitude equals the smaller of the two input magnitudes.
- R2: In check mode the output sign is the XOR of the two input sign bits whenever the output magnitude is nonzero.
- R3: In bit mode (`mode_g`=1) with `psum`=0 the output equals `llr_b` + `llr_a`.
- R4: In bit mode with `psum`=1 the output equals `llr_b` − `llr_a`.
- R5: A bit-mode result whose magnitude exceeds 2^(W−1)−1 is clipped to that magnitude and keeps the sign of the true result.
- R6: An output of magnitude zero always carries sign bit 0. This includes results built from negative-zero inputs.
- R7: `a_gt_b` is 1 exactly when the magnitude of `llr_a` is strictly greater than that of `llr_b`, in both modes.
- R8: With `OUT_REG`=1, `llr_out` and `a_gt_b` reflect the inputs present at the previous rising clock edge. While `rst_n` is low they are held at 0.
- R9: Soft values use bit W−1 as the sign (1 = negative) and bits W−2..0 as the magnitude. An input of negative zero is treated as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_g | input | 1 | 0 = check (min-sum) mode, 1 = bit (add/subtract) mode |
| psum | input | 1 | Partial-sum bit; 1 selects subtraction in bit mode |
| llr_a | input | W | First soft input, sign-magnitude |
| llr_b | input | W | Second soft input, sign-magnitude |
| llr_out | output | W | Soft result, sign-magnitude |
| a_gt_b | output | 1 | Magnitude of `llr_a` strictly greater than magnitude of `llr_b` |

## Verification
Every pairing of the two inputs at the default 5-bit width is applied under all four settings of mode and partial sum. This separates the min-sum path from the two adder paths and exposes any swapped operand, since `llr_b` − `llr_a` differs from the reverse order. Directed cases then single out the extremes. Opposite-sign full-scale inputs must saturate in both directions, and equal magnitudes of opposite sign must cancel to a positive zero. Negative-zero inputs must behave exactly like positive zero, and equal magnitudes must leave the comparison flag low.

// File: rtl/polar_pe_pkg.sv
// Package: shared types for the polar processing element.
// Assumes: nothing beyond standard SystemVerilog.
package polar_pe_pkg;

    // Operating mode of the processing element.
    typedef enum logic {
        PE_CHECK = 1'b0,
        PE_BIT   = 1'b1
    } pe_mode_e;

endpackage : polar_pe_pkg

// File: rtl/pe_sm_to_tc.sv
// Module: pe_sm_to_tc
// Converts a sign-magnitude value into two's complement of the same width.
// Assumes: the MSB is the sign and the remaining bits are the magnitude.
// A negative zero maps to 0.
module pe_sm_to_tc #(
    parameter int W = 5
) (
    input  logic [W-1:0] sm_in,
    output logic [W-1:0] tc_out
);
    localparam int MW = W - 1;

    logic [W-1:0] mag_ext;

    // Zero-extend the magnitude and negate it when the sign is set.
    always_comb begin
        mag_ext = {1'b0, sm_in[MW-1:0]};
        tc_out  = sm_in[W-1] ? (~mag_ext + 1'b1) : mag_ext;
    end
endmodule : pe_sm_to_tc

// File: rtl/pe_tc_to_sm_sat.sv
// Module: pe_tc_to_sm_sat
// Converts a wide two's-complement value back to W-bit sign-magnitude.
// Magnitudes beyond 2^(W-1)-1 are clipped, and a zero result always
// gets a positive sign.
// Assumes: IW > W, so the input may carry a magnitude the output cannot hold.
module pe_tc_to_sm_sat #(
    parameter int W  = 5,
    parameter int IW = W + 1
) (
    input  logic [IW-1:0] tc_in,
    output logic [W-1:0]  sm_out
);
    localparam int            MW     = W - 1;
    localparam logic [IW-1:0] MAXABS = IW'((1 << MW) - 1);

    logic [IW-1:0] abs_val;
    logic [MW-1:0] mag;
    logic          neg;

    // Take the absolute value, clip it to the output range and rebuild the sign.
    always_comb begin
        neg     = tc_in[IW-1];
        abs_val = neg ? (~tc_in + 1'b1) : tc_in;
        mag     = (abs_val > MAXABS) ? MAXABS[MW-1:0] : abs_val[MW-1:0];
        sm_out  = {neg & (mag != '0), mag};
    end
endmodule : pe_tc_to_sm_sat

// File: rtl/pe_minsum_cmp.sv
// Module: pe_minsum_cmp
// Comparator-selector for the check update. It outputs the smaller magnitude,
// with the XOR of the input signs, and a "first greater than second" flag.
// Assumes: sign-magnitude inputs. A zero result is given a positive sign.
module pe_minsum_cmp #(
    parameter int W = 5
) (
    input  logic [W-1:0] a_sm,
    input  logic [W-1:0] b_sm,
    output logic [W-1:0] f_sm,
    output logic         a_gt_b
);
    localparam int MW = W - 1;

    logic [MW-1:0] mag_min;

    // Compare the magnitudes, keep the smaller one and combine the signs.
    always_comb begin
        a_gt_b  = a_sm[MW-1:0] > b_sm[MW-1:0];
        mag_min = a_gt_b ? b_sm[MW-1:0] : a_sm[MW-1:0];
        f_sm    = {(a_sm[W-1] ^ b_sm[W-1]) & (mag_min != '0), mag_min};
    end
endmodule : pe_minsum_cmp

// File: rtl/polar_fg_pe.sv
// Module: polar_fg_pe
// Unified check/bit processing element for LLR-domain SC polar decoding.
// Check mode: min-sum. Bit mode: llr_b +/- llr_a (subtract when psum=1), saturated.
// Assumes: sign-magnitude ports. OUT_REG=1 adds one register stage that is
// cleared by a synchronous active-low reset.
module polar_fg_pe
    import polar_pe_pkg::*;
#(
    parameter int W       = 5,
    parameter bit OUT_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_g,
    input  logic         psum,
    input  logic [W-1:0] llr_a,
    input  logic [W-1:0] llr_b,
    output logic [W-1:0] llr_out,
    output logic         a_gt_b
);
    localparam int SW = W + 1;

    pe_mode_e      mode;
    logic [W-1:0]  in_sm   [2];
    logic [W-1:0]  in_tc   [2];
    logic [SW-1:0] arith   [2];
    logic [W-1:0]  arith_sm[2];
    logic [W-1:0]  f_res;
    logic [W-1:0]  g_res;
    logic [W-1:0]  res_nxt;
    logic          gt_nxt;

    assign in_sm[0] = llr_a;
    assign in_sm[1] = llr_b;

    // One input converter per operand.
    for (genvar i = 0; i < 2; i++) begin : g_in_conv
        pe_sm_to_tc #(.W(W)) u_s2t (
            .sm_in (in_sm[i]),
            .tc_out(in_tc[i])
        );
    end

    // Sum and difference are formed in parallel at one extra bit of width.
    always_comb begin
        arith[0] = {in_tc[1][W-1], in_tc[1]} + {in_tc[0][W-1], in_tc[0]};
        arith[1] = {in_tc[1][W-1], in_tc[1]} - {in_tc[0][W-1], in_tc[0]};
    end

    // One saturating output converter per arithmetic result.
    for (genvar i = 0; i < 2; i++) begin : g_out_conv
        pe_tc_to_sm_sat #(.W(W), .IW(SW)) u_t2s (
            .tc_in (arith[i]),
            .sm_out(arith_sm[i])
        );
    end

    pe_minsum_cmp #(.W(W)) u_cmp (
        .a_sm  (llr_a),
        .b_sm  (llr_b),
        .f_sm  (f_res),
        .a_gt_b(gt_nxt)
    );

    // The partial sum picks the bit result; the mode picks check or bit.
    always_comb begin
        mode    = pe_mode_e'(mode_g);
        g_res   = psum ? arith_sm[1] : arith_sm[0];
        res_nxt = (mode == PE_BIT) ? g_res : f_res;
    end

    if (OUT_REG) begin : g_reg
        // Register the result and the comparison flag; reset clears both.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                llr_out <= '0;
                a_gt_b  <= 1'b0;
            end else begin
                llr_out <= res_nxt;
                a_gt_b  <= gt_nxt;
            end
        end
    end else begin : g_comb
        assign llr_out = res_nxt;
        assign a_gt_b  = gt_nxt;
    end
endmodule : polar_fg_pe

// File: rtl/polar_fg_pe_chk.sv
// Module: polar_fg_pe_chk
// Property checker for polar_fg_pe, attached with bind.
// It aligns the inputs to the output latency and relates them to the outputs.
// Assumes: the same W and OUT_REG as the bound instance.
module polar_fg_pe_chk #(
    parameter int W       = 5,
    parameter bit OUT_REG = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         mode_g,
    input logic         psum,
    input logic [W-1:0] llr_a,
    input logic [W-1:0] llr_b,
    input logic [W-1:0] llr_out,
    input logic         a_gt_b
);
    localparam int MW     = W - 1;
    localparam int MAXMAG = (1 << MW) - 1;

    logic         vld;
    logic         d_g, d_p;
    logic [W-1:0] d_a, d_b;

    // Marks cycles after the first clock out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) vld <= 1'b0;
        else        vld <= 1'b1;
    end

    if (OUT_REG) begin : g_dly
        // Delay the inputs by the register stage of the element.
        always_ff @(posedge clk) begin
            d_g <= mode_g;
            d_p <= psum;
            d_a <= llr_a;
            d_b <= llr_b;
        end
    end else begin : g_nodly
        assign d_g = mode_g;
        assign d_p = psum;
        assign d_a = llr_a;
        assign d_b = llr_b;
    end

    function automatic int sm_val(input logic [W-1:0] x);
        int m;
        m = int'(x[MW-1:0]);
        return x[W-1] ? -m : m;
    endfunction

    function automatic int clip(input int v);
        if (v > MAXMAG)  return MAXMAG;
        if (v < -MAXMAG) return -MAXMAG;
        return v;
    endfunction

    int a_mag, b_mag, min_mag, ideal;
    always_comb begin
        a_mag   = int'(d_a[MW-1:0]);
        b_mag   = int'(d_b[MW-1:0]);
        min_mag = (a_mag < b_mag) ? a_mag : b_mag;
        ideal   = d_p ? (sm_val(d_b) - sm_val(d_a)) : (sm_val(d_b) + sm_val(d_a));
    end

    p_f_min_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !d_g) |-> (int'(llr_out[MW-1:0]) == min_mag));

    p_f_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !d_g && llr_out[MW-1:0] != '0) |-> (llr_out[W-1] == (d_a[W-1] ^ d_b[W-1])));

    p_g_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && d_g && !d_p) |-> (sm_val(llr_out) == clip(ideal)));

    p_g_diff_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && d_g && d_p) |-> (sm_val(llr_out) == clip(ideal)));

    p_g_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && d_g && (ideal > MAXMAG || ideal < -MAXMAG))
            |-> (int'(llr_out[MW-1:0]) == MAXMAG && llr_out[W-1] == (ideal < 0)));

    p_zero_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && llr_out[MW-1:0] == '0) |-> !llr_out[W-1]);

    p_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> (a_gt_b == (a_mag > b_mag)));

endmodule : polar_fg_pe_chk

bind polar_fg_pe polar_fg_pe_chk #(.W(W), .OUT_REG(OUT_REG)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_g (mode_g),
    .psum   (psum),
    .llr_a  (llr_a),
    .llr_b  (llr_b),
    .llr_out(llr_out),
    .a_gt_b (a_gt_b)
);

// File: tb/polar_fg_pe_tb_top.sv
// Directed and exhaustive bench for polar_fg_pe at the default 5-bit width.
// Inputs are driven at the falling edge, and results are sampled at the next falling edge.
module polar_fg_pe_tb_top;
    localparam int  W       = 5;
    localparam int  MW      = W - 1;
    localparam int  MAXMAG  = (1 << MW) - 1;
    localparam time CLK_PER = 10ns;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         mode_g;
    logic         psum;
    logic [W-1:0] llr_a;
    logic [W-1:0] llr_b;
    logic [W-1:0] llr_out;
    logic         a_gt_b;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PER / 2) clk = ~clk;

    polar_fg_pe #(.W(W), .OUT_REG(1'b1)) dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_g (mode_g),
        .psum   (psum),
        .llr_a  (llr_a),
        .llr_b  (llr_b),
        .llr_out(llr_out),
        .a_gt_b (a_gt_b)
    );

    // Model of the encoding (R9): bit W-1 is the sign, and the low bits are the magnitude.
    function automatic int to_int(input logic [W-1:0] x);
        int m;
        m = int'(x[MW-1:0]);
        return x[W-1] ? -m : m;
    endfunction

    function automatic logic [W-1:0] to_sm(input int v);
        int c;
        c = (v > MAXMAG) ? MAXMAG : ((v < -MAXMAG) ? -MAXMAG : v);
        return (c < 0) ? {1'b1, MW'(-c)} : {1'b0, MW'(c)};
    endfunction

    function automatic logic [W-1:0] model(input logic g, input logic p,
                                           input logic [W-1:0] a, input logic [W-1:0] b);
        int am, bm, mn;
        if (g) return to_sm(p ? to_int(b) - to_int(a) : to_int(b) + to_int(a));
        am = int'(a[MW-1:0]);
        bm = int'(b[MW-1:0]);
        mn = (am < bm) ? am : bm;
        return {(a[W-1] ^ b[W-1]) && mn != 0, MW'(mn)};
    endfunction

    task automatic check_out(input string req, input logic [W-1:0] exp_v);
        n_tests++;
        if (llr_out !== exp_v) begin
            n_fail++;
            $display("FAIL %s llr_out actual=%b expected=%b (a=%b b=%b g=%b p=%b)",
                     req, llr_out, exp_v, llr_a, llr_b, mode_g, psum);
        end
    endtask

    task automatic check_flag(input string req, input logic exp_v);
        n_tests++;
        if (a_gt_b !== exp_v) begin
            n_fail++;
            $display("FAIL %s a_gt_b actual=%b expected=%b (a=%b b=%b)",
                     req, a_gt_b, exp_v, llr_a, llr_b);
        end
    endtask

    // Apply one vector and check both outputs one clock later (R8 latency).
    task automatic apply(input string req, input logic g, input logic p,
                         input logic [W-1:0] a, input logic [W-1:0] b);
        mode_g = g; psum = p; llr_a = a; llr_b = b;
        @(negedge clk);
        check_out(req, model(g, p, a, b));
        check_flag("R7", a[MW-1:0] > b[MW-1:0]);
    endtask

    // R8: reset holds both outputs at zero whatever the inputs.
    task automatic t_reset();
        rst_n = 1'b0;
        mode_g = 1'b1; psum = 1'b0; llr_a = 5'b0_1111; llr_b = 5'b0_1111;
        @(negedge clk);
        @(negedge clk);
        check_out("R8", '0);
        check_flag("R8", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R8", 5'b0_1111);
    endtask

    // R1 R2: every input pair in check mode, with psum set both ways.
    task automatic t_check_all();
        for (int p = 0; p < 2; p++)
            for (int a = 0; a < (1 << W); a++)
                for (int b = 0; b < (1 << W); b++)
                    apply("R1/R2", 1'b0, p[0], W'(a), W'(b));
    endtask

    // R3 R4: every input pair in bit mode for both partial sums.
    task automatic t_bit_all();
        for (int a = 0; a < (1 << W); a++)
            for (int b = 0; b < (1 << W); b++) begin
                apply("R3", 1'b1, 1'b0, W'(a), W'(b));
                apply("R4", 1'b1, 1'b1, W'(a), W'(b));
            end
    endtask

    // R5 R6 R9 R7: directed corner values with expectations written out.
    task automatic t_corners();
        mode_g = 1'b1; psum = 1'b0; llr_a = 5'b0_1111; llr_b = 5'b0_1010;
        @(negedge clk); check_out("R5", 5'b0_1111);
        psum = 1'b1; llr_a = 5'b0_1100; llr_b = 5'b1_0111;
        @(negedge clk); check_out("R5", 5'b1_1111);
        psum = 1'b0; llr_a = 5'b1_0110; llr_b = 5'b0_0110;
        @(negedge clk); check_out("R6", 5'b0_0000);
        mode_g = 1'b0; llr_a = 5'b1_0000; llr_b = 5'b0_0101;
        @(negedge clk); check_out("R6", 5'b0_0000);
        mode_g = 1'b1; psum = 1'b1; llr_a = 5'b1_0000; llr_b = 5'b1_0011;
        @(negedge clk); check_out("R9", 5'b1_0011);
        mode_g = 1'b0; llr_a = 5'b1_0111; llr_b = 5'b0_0111;
        @(negedge clk); check_out("R2", 5'b1_0111); check_flag("R7", 1'b0);
        mode_g = 1'b1; llr_a = 5'b0_1000; llr_b = 5'b1_0111;
        @(negedge clk); check_flag("R7", 1'b1);
    endtask

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        #(CLK_PER * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode_g = 1'b0; psum = 1'b0; llr_a = '0; llr_b = '0;
        @(negedge clk);
        t_reset();
        t_check_all();
        t_bit_all();
        t_corners();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule : polar_fg_pe_tb_top